// File: doc/BRIEF.md
# Round-robin ADC channel sequencer

This block sits in front of a multiplexed analog-to-digital converter and turns it into a scanning engine. Software fills a small table of slots. Each slot names one of sixteen analog inputs and can carry an end-of-scan marker. When the block is enabled and started, it asks the converter for one sample per slot. It walks upward from slot zero and stops after the first slot that carries the marker. Each 10-bit sample lands in a per-slot result register.

At the end of each pass a round-complete status bit is raised, and that bit can drive an interrupt. The pass then repeats, after an optional programmable pause, for as long as start remains set. A hold bit lets software freeze every visible result. It can then read a snapshot that is consistent across all slots. Passes that complete during the hold are parked and published when the hold is released.

The register bus is a plain synchronous address/write-enable/data port with registered read data. The converter side is a level request with a channel number, answered by a one-cycle done strobe that carries the sample.

Top module: `adcseq_top`

## Requirements
- R1: After reset, control, hold, status and mask read 0, every result reads 0, slot 0 reads 0x10 (stop marker only, channel 0), the other slots read 0, and `irq` and `cnv_req` are low.
- R2: Slot i sits at address 0x10+i, with the channel in bits 3:0 and the stop marker in bit 4. The result of slot n reads at 0x20+2n as result bits 9:2, and at 0x21+2n as result bits 1:0 in data bits 1:0. Read data appears one clock after the address.
- R3: A pass requests slots in increasing order from slot 0, and `cnv_chan` carries the slot's channel while the request is held. The pass ends after the lowest slot with the stop marker set, or after slot 14 if no marker is set, so a pass makes (stop slot + 1) conversions.
- R4: While enable and start stay set, passes repeat. Between passes `cnv_req` is low for exactly sleep*4 cycles, and a sleep of 0 gives back-to-back passes.
- R5: Each accepted conversion stores its 10-bit sample as that slot's result.
- R6: While the hold bit (address 0x01, bit 0) is set, visible results do not change. Samples that complete meanwhile are kept aside, round-complete is still raised, and clearing hold publishes the kept samples.
- R7: Clearing start lets the conversion in progress finish and store its result. The block then goes idle with no new request, and raises round-complete only if that slot ended the pass.
- R8: Clearing enable drops `cnv_req` on the clock after the control register changes, and a later done strobe is ignored.
- R9: Status (address 0x02) holds round-complete in bit 0, the `burst_evt` input in bit 1 and the `calib_evt` input in bit 2. Each bit stays set until a 1 is written to it. Writing 0 has no effect, and an event in the same cycle as its clear leaves the bit set.
- R10: `irq` is the OR of the status bits ANDed with the mask register (address 0x03, bits 2:0), registered one clock after status.
- R11: Control (address 0x00) holds enable in bit 4, start in bit 3 and sleep in bits 2:0, and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| burst_evt | input | 1 | Pulse that sets status bit 1 |
| calib_evt | input | 1 | Pulse that sets status bit 2 |
| cnv_req | output | 1 | Conversion request, held until done |
| cnv_chan | output | 4 | Channel to convert |
| cnv_done | input | 1 | One-cycle conversion complete strobe |
| cnv_data | input | 10 | Sample, valid with cnv_done |
| irq | output | 1 | Masked interrupt |

## Verification
On every cycle, the assertions check four things. Visible results stay frozen whenever hold was set on the previous edge. An enable of zero removes the request on the next clock. The channel stays steady while a request is outstanding. Each round-complete pulse follows an accepted done and leaves a sticky status bit.

Some behaviour needs whole scenarios instead: the number of conversions in a pass for different stop positions, the exact pause length between passes, the publishing of parked samples once hold is released, and the graceful finish after start is cleared. The bench shows these.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2
  } seq_state_e;

  // register addresses
  localparam int A_CTRL = 'h00;
  localparam int A_HOLD = 'h01;
  localparam int A_STAT = 'h02;
  localparam int A_MASK = 'h03;
  localparam int A_SLOT = 'h10;
  localparam int A_RES  = 'h20;

  // control field layout
  localparam int EN_BIT  = 4;
  localparam int GO_BIT  = 3;
  localparam int SLEEP_W = 3;

  // status bit positions
  localparam int STAT_W   = 3;
  localparam int SB_ROUND = 0;
  localparam int SB_BURST = 1;
  localparam int SB_CAL   = 2;
endpackage

// File: rtl/adcseq_engine.sv
module adcseq_engine
  import adcseq_pkg::*;
#(
  parameter int NUM_SLOTS  = 15,
  parameter int CH_W       = 4,
  parameter int RES_W      = 10,
  parameter int SLEEP_UNIT = 4,
  localparam int IDX_W     = $clog2(NUM_SLOTS),
  localparam int CNT_W     = $clog2(SLEEP_UNIT * (2 ** SLEEP_W)) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      go,
  input  logic [SLEEP_W-1:0]        sleep_sel,
  input  logic [NUM_SLOTS*CH_W-1:0] slot_chan,
  input  logic [NUM_SLOTS-1:0]      slot_stop,
  input  logic                      cnv_done,
  input  logic [RES_W-1:0]          cnv_data,
  output logic                      cnv_req,
  output logic [CH_W-1:0]           cnv_chan,
  output logic                      wr_vld,
  output logic [IDX_W-1:0]          wr_idx,
  output logic [RES_W-1:0]          wr_data,
  output logic                      round_done
);
  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nap;
  logic             last_slot;
  logic             wr_vld_q, round_q;
  logic [IDX_W-1:0] wr_idx_q;
  logic [RES_W-1:0] wr_data_q;

  assign last_slot = slot_stop[idx_q] || (idx_q == IDX_W'(NUM_SLOTS - 1));
  assign nap       = CNT_W'(sleep_sel) * CNT_W'(SLEEP_UNIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      wr_vld_q  <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      round_q   <= 1'b0;
    end else begin
      wr_vld_q <= 1'b0;
      round_q  <= 1'b0;
      if (!en) begin
        st_q  <= ST_IDLE;
        idx_q <= '0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (go) begin
              st_q  <= ST_CONV;
              idx_q <= '0;
            end
          end
          ST_CONV: begin
            if (cnv_done) begin
              wr_vld_q  <= 1'b1;
              wr_idx_q  <= idx_q;
              wr_data_q <= cnv_data;
              round_q   <= last_slot;
              if (!go) begin
                st_q  <= ST_IDLE;
                idx_q <= '0;
              end else if (!last_slot) begin
                idx_q <= idx_q + 1'b1;
              end else begin
                idx_q <= '0;
                if (nap != '0) begin
                  st_q  <= ST_SLEEP;
                  cnt_q <= nap - 1'b1;
                end
              end
            end
          end
          ST_SLEEP: begin
            if (!go) st_q <= ST_IDLE;
            else if (cnt_q == '0) st_q <= ST_CONV;
            else cnt_q <= cnt_q - 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cnv_req    = (st_q == ST_CONV);
  assign cnv_chan   = slot_chan[idx_q*CH_W +: CH_W];
  assign wr_vld     = wr_vld_q;
  assign wr_idx     = wr_idx_q;
  assign wr_data    = wr_data_q;
  assign round_done = round_q;
endmodule

// File: rtl/adcseq_results.sv
module adcseq_results #(
  parameter int NUM_SLOTS = 15,
  parameter int RES_W     = 10,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hold,
  input  logic                       wr_vld,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [RES_W-1:0]           wr_data,
  output logic [NUM_SLOTS*RES_W-1:0] vis_flat
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [RES_W-1:0] vis_q, pend_q;
    logic             dirty_q;
    logic             hit;

    assign hit = wr_vld && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        vis_q   <= '0;
        pend_q  <= '0;
        dirty_q <= 1'b0;
      end else if (hit) begin
        if (hold) begin
          pend_q  <= wr_data;
          dirty_q <= 1'b1;
        end else begin
          vis_q   <= wr_data;
          dirty_q <= 1'b0;
        end
      end else if (!hold && dirty_q) begin
        vis_q   <= pend_q;
        dirty_q <= 1'b0;
      end
    end

    assign vis_flat[i*RES_W +: RES_W] = vis_q;
  end
endmodule

// File: rtl/adcseq_csr.sv
module adcseq_csr
  import adcseq_pkg::*;
#(
  parameter int NUM_SLOTS = 15,
  parameter int CH_W      = 4,
  parameter int RES_W     = 10,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       round_done,
  input  logic                       burst_evt,
  input  logic                       calib_evt,
  input  logic [NUM_SLOTS*RES_W-1:0] res_flat,
  output logic                       en,
  output logic                       go,
  output logic [SLEEP_W-1:0]         sleep_sel,
  output logic                       hold,
  output logic [NUM_SLOTS*CH_W-1:0]  slot_chan,
  output logic [NUM_SLOTS-1:0]       slot_stop,
  output logic [STAT_W-1:0]          stat,
  output logic                       irq
);
  localparam int CTRL_W = EN_BIT + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              hold_q;
  logic [STAT_W-1:0] stat_q, mask_q, stat_clr, stat_set;
  logic              irq_q;
  logic [DATA_W-1:0] rd_nx, rdata_q;
  logic [CH_W:0]     slot_q [NUM_SLOTS];
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  function automatic logic hit(input int a);
    return bus_we && (bus_addr == ADDR_W'(a));
  endfunction

  assign stat_clr = hit(A_STAT) ? bus_wdata[STAT_W-1:0] : '0;
  always_comb begin
    stat_set           = '0;
    stat_set[SB_ROUND] = round_done;
    stat_set[SB_BURST] = burst_evt;
    stat_set[SB_CAL]   = calib_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      hold_q <= 1'b0;
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (hit(A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (hit(A_HOLD)) hold_q <= bus_wdata[0];
      if (hit(A_MASK)) mask_q <= bus_wdata[STAT_W-1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      irq_q  <= |(stat_q & mask_q);
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [CH_W:0] RST_V = (i == 0) ? {1'b1, {CH_W{1'b0}}} : '0;
    always_ff @(posedge clk) begin
      if (rst) slot_q[i] <= RST_V;
      else if (hit(A_SLOT + i)) slot_q[i] <= bus_wdata[CH_W:0];
    end
    assign slot_chan[i*CH_W +: CH_W] = slot_q[i][CH_W-1:0];
    assign slot_stop[i]              = slot_q[i][CH_W];
  end

  always_comb begin
    rd_nx = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) rd_nx = DATA_W'(ctrl_q);
    if (bus_addr == ADDR_W'(A_HOLD)) rd_nx = DATA_W'(hold_q);
    if (bus_addr == ADDR_W'(A_STAT)) rd_nx = DATA_W'(stat_q);
    if (bus_addr == ADDR_W'(A_MASK)) rd_nx = DATA_W'(mask_q);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (bus_addr == ADDR_W'(A_SLOT + i)) rd_nx = DATA_W'(slot_q[i]);
      if (bus_addr == ADDR_W'(A_RES + 2*i))
        rd_nx = DATA_W'(res_flat[i*RES_W+2 +: RES_W-2]);
      if (bus_addr == ADDR_W'(A_RES + 2*i + 1))
        rd_nx = DATA_W'(res_flat[i*RES_W +: 2]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nx;
  end

  assign bus_rdata = rdata_q;
  assign en        = ctrl_q[EN_BIT];
  assign go        = ctrl_q[GO_BIT];
  assign sleep_sel = ctrl_q[SLEEP_W-1:0];
  assign hold      = hold_q;
  assign stat      = stat_q;
  assign irq       = irq_q;
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NUM_SLOTS  = 15,
  parameter int CH_W       = 4,
  parameter int RES_W      = 10,
  parameter int SLEEP_UNIT = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              burst_evt,
  input  logic              calib_evt,
  output logic              cnv_req,
  output logic [CH_W-1:0]   cnv_chan,
  input  logic              cnv_done,
  input  logic [RES_W-1:0]  cnv_data,
  output logic              irq
);
  logic                       en_w, go_w, hold_w, round_w, wr_vld_w;
  logic [SLEEP_W-1:0]         sleep_w;
  logic [NUM_SLOTS*CH_W-1:0]  chan_w;
  logic [NUM_SLOTS-1:0]       stop_w;
  logic [STAT_W-1:0]          stat_w;
  logic [IDX_W-1:0]           wr_idx_w;
  logic [RES_W-1:0]           wr_data_w;
  logic [NUM_SLOTS*RES_W-1:0] res_w;

  adcseq_csr #(
    .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .RES_W(RES_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_csr (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .round_done(round_w), .burst_evt(burst_evt), .calib_evt(calib_evt),
    .res_flat(res_w),
    .en(en_w), .go(go_w), .sleep_sel(sleep_w), .hold(hold_w),
    .slot_chan(chan_w), .slot_stop(stop_w), .stat(stat_w), .irq(irq)
  );

  adcseq_engine #(
    .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .RES_W(RES_W), .SLEEP_UNIT(SLEEP_UNIT)
  ) u_eng (
    .clk(clk), .rst(rst),
    .en(en_w), .go(go_w), .sleep_sel(sleep_w),
    .slot_chan(chan_w), .slot_stop(stop_w),
    .cnv_done(cnv_done), .cnv_data(cnv_data),
    .cnv_req(cnv_req), .cnv_chan(cnv_chan),
    .wr_vld(wr_vld_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .round_done(round_w)
  );

  adcseq_results #(
    .NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)
  ) u_res (
    .clk(clk), .rst(rst), .hold(hold_w),
    .wr_vld(wr_vld_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .vis_flat(res_w)
  );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk
  import adcseq_pkg::*;
#(
  parameter int NUM_SLOTS = 15,
  parameter int CH_W      = 4,
  parameter int RES_W     = 10,
  parameter int ADDR_W    = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic                       hold,
  input logic [NUM_SLOTS*RES_W-1:0] res_flat,
  input logic                       stat_round,
  input logic                       round_done,
  input logic                       cnv_req,
  input logic                       cnv_done,
  input logic [CH_W-1:0]            cnv_chan,
  input logic                       bus_we,
  input logic [ADDR_W-1:0]          bus_addr
);
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    $past(hold) |-> $stable(res_flat)); // R6

  AST_ABORT_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    !en |=> !cnv_req); // R8

  AST_CHAN_STEADY: assert property (@(posedge clk) disable iff (rst)
    (cnv_req && !cnv_done && en) |=> (cnv_req && $stable(cnv_chan))); // R3

  AST_ROUND_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    round_done |-> $past(cnv_req && cnv_done)); // R3

  AST_ROUND_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
    round_done |=> stat_round); // R9

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(stat_round) && !$past(bus_we && (bus_addr == ADDR_W'(A_STAT))))
      |-> stat_round); // R9
endmodule

bind adcseq_top adcseq_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .RES_W(RES_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en_w), .hold(hold_w), .res_flat(res_w),
  .stat_round(stat_w[0]), .round_done(round_w),
  .cnv_req(cnv_req), .cnv_done(cnv_done), .cnv_chan(cnv_chan),
  .bus_we(bus_we), .bus_addr(bus_addr)
);

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  localparam int WD_CYCLES  = 150000;

  // vector fields: stop slot [17:14] (15 = no marker), channel step [13:10], base [9:0]
  localparam logic [17:0] VECS [4] = '{
    {4'd0,  4'd3, 10'd10},
    {4'd4,  4'd5, 10'd300},
    {4'd14, 4'd7, 10'd600},
    {4'd15, 4'd2, 10'd900}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       burst_evt = 1'b0;
  logic       calib_evt = 1'b0;
  logic       cnv_req;
  logic [3:0] cnv_chan;
  logic       cnv_done = 1'b0;
  logic [9:0] cnv_data = '0;
  logic       irq;

  int n_chk = 0, n_err = 0;
  int conv_base = 0, conv_cnt = 0;
  int gap = 0, last_gap = 0;

  adcseq_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .burst_evt(burst_evt), .calib_evt(calib_evt),
    .cnv_req(cnv_req), .cnv_chan(cnv_chan), .cnv_done(cnv_done),
    .cnv_data(cnv_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // converter stub
  initial begin
    forever begin
      @(negedge clk);
      if (cnv_req && !rst) begin
        repeat (LAT - 1) @(negedge clk);
        cnv_data = 10'(conv_base + int'(cnv_chan));
        cnv_done = 1'b1;
        conv_cnt++;
        @(negedge clk);
        cnv_done = 1'b0;
      end
    end
  end

  // request-low run length monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!cnv_req) gap++;
      else begin
        if (gap > 0) last_gap = gap;
        gap = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_addr  = 8'(a);
    bus_wdata = 8'(d);
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = 8'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic rd_res(input int n, output int v);
    int hi, lo;
    rd('h20 + 2*n, hi);
    rd('h21 + 2*n, lo);
    v = hi * 4 + lo;
  endtask

  task automatic run_one_pass();
    wr('h02, 7);
    repeat (3) @(negedge clk);
    wr('h00, 'h18);
    while (!irq) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_err++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v, snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 req", int'(cnv_req), 0);
    check("R1 irq", int'(irq), 0);
    rd('h00, v); check("R1 ctrl", v, 0);
    rd('h01, v); check("R1 hold", v, 0);
    rd('h02, v); check("R1 status", v, 0);
    rd('h03, v); check("R1 mask", v, 0);
    rd('h10, v); check("R1 slot0", v, 'h10);
    rd('h11, v); check("R1 slot1", v, 0);
    rd_res(0, v); check("R1 result0", v, 0);

    // table-driven passes: R3 length, R5 stored samples, R2 map
    for (int k = 0; k < 4; k++) begin
      int stop, step, base, expn;
      stop = int'(VECS[k][17:14]);
      step = int'(VECS[k][13:10]);
      base = int'(VECS[k][9:0]);
      expn = (stop == 15) ? 15 : stop + 1;
      wr('h00, 0);
      for (int n = 0; n < 15; n++)
        wr('h10 + n, (((n == stop) ? 1 : 0) << 4) | ((n * step + 1) % 16));
      rd('h12, v); check("R2 slot readback", v, (((stop == 2) ? 16 : 0)) | ((2 * step + 1) % 16));
      conv_base = base;
      wr('h03, 1);
      conv_cnt = 0;
      run_one_pass();
      snap = conv_cnt;
      check("R3 conversions per pass", snap, expn);
      wr('h00, 'h10);
      repeat (20) @(negedge clk);
      check("R7 idle after start cleared", int'(cnv_req), 0);
      for (int n = 0; n < expn; n++) begin
        rd_res(n, v);
        check("R5 R2 result", v, base + ((n * step + 1) % 16));
      end
    end

    // R4 / R11 inter-pass pause
    wr('h00, 0);
    wr('h10, 'h15);
    wr('h00, 'h1A);
    rd('h00, v); check("R11 ctrl readback", v, 'h1A);
    conv_cnt = 0;
    wait (conv_cnt == 3);
    check("R4 pause sleep=2", last_gap, 8);
    wr('h00, 'h19);
    conv_cnt = 0;
    wait (conv_cnt == 3);
    check("R4 pause sleep=1", last_gap, 4);
    wr('h00, 0);
    repeat (20) @(negedge clk);

    // R6 hold snapshot
    wr('h10, 1); wr('h11, 2); wr('h12, 'h13);
    conv_base = 100;
    wr('h03, 1);
    run_one_pass();
    wr('h00, 'h10);
    repeat (20) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      rd_res(n, v); check("R5 hold baseline", v, 101 + n);
    end
    wr('h01, 1);
    conv_base = 200;
    run_one_pass();
    wr('h00, 'h10);
    repeat (20) @(negedge clk);
    rd('h02, v); check("R6 round-complete under hold", v & 1, 1);
    for (int n = 0; n < 3; n++) begin
      rd_res(n, v); check("R6 frozen", v, 101 + n);
    end
    wr('h01, 0);
    repeat (2) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      rd_res(n, v); check("R6 published", v, 201 + n);
    end

    // R7 graceful stop mid-pass
    wr('h00, 0);
    wr('h02, 7);
    wr('h03, 0);
    conv_base = 400;
    conv_cnt = 0;
    wr('h00, 'h18);
    wait (conv_cnt == 1);
    @(negedge clk);
    wr('h00, 'h10);
    repeat (30) @(negedge clk);
    check("R7 conversions", conv_cnt, 2);
    check("R7 request low", int'(cnv_req), 0);
    rd('h02, v); check("R7 no round-complete", v & 1, 0);
    rd_res(1, v); check("R7 last sample stored", v, 402);
    rd_res(2, v); check("R7 later slot untouched", v, 203);

    // R8 abort by enable
    conv_base = 500;
    conv_cnt = 0;
    wr('h00, 'h18);
    wait (conv_cnt == 1);
    @(negedge clk);
    wr('h00, 0);
    @(negedge clk);
    check("R8 request dropped", int'(cnv_req), 0);
    repeat (20) @(negedge clk);
    rd_res(0, v); check("R8 first sample", v, 501);
    rd_res(1, v); check("R8 late done ignored", v, 402);

    // R9 / R10 status and interrupt
    wr('h02, 7);
    wr('h03, 0);
    burst_evt = 1'b1;
    @(negedge clk);
    burst_evt = 1'b0;
    rd('h02, v); check("R9 burst sets bit1", v, 2);
    repeat (2) @(negedge clk);
    check("R10 masked irq", int'(irq), 0);
    wr('h03, 2);
    repeat (2) @(negedge clk);
    check("R10 unmasked irq", int'(irq), 1);
    wr('h02, 1);
    rd('h02, v); check("R9 other-bit clear no effect", v, 2);
    wr('h02, 2);
    rd('h02, v); check("R9 write-one clears", v, 0);
    repeat (2) @(negedge clk);
    check("R10 irq falls", int'(irq), 0);
    bus_addr = 8'h02; bus_wdata = 8'h04; bus_we = 1'b1; calib_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; calib_evt = 1'b0;
    rd('h02, v); check("R9 event beats clear", v, 4);
    rd('h03, v); check("R10 mask readback", v, 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule